// File: doc/BRIEF.md
# Configurable SPI Serial Channel

A single serial channel that moves 7- or 8-bit frames over SPI, as bus master or as slave. As master, it makes the serial clock from one of two operation-clock enables. A 7-bit reload value N sets the rate: every half period of the serial clock lasts N+1 enabled cycles. As slave, it follows an external serial clock and a slave-select line. It brings both into its own clock domain with two-flop synchronizers.

Software writes a transmit holding register and reads a receive register. It watches a busy flag, a transmit-empty flag, an event pulse and a sticky overrun flag. A two-bit clock-mode code picks the idle level of the serial clock and which edge samples the data. Other fields pick the bit order, the frame length, the data direction and the event style. The event style is either one pulse per finished frame, or one pulse whenever the holding register empties.

Top module: `spi_channel`

## Requirements
- R1: In master mode each half period of `sclk_o` lasts `cfg_div`+1 pulses of the selected operation-clock enable (`cfg_ck_sel`=0 picks `ck0_en`, 1 picks `ck1_en`).
- R2: `cfg_mode` bit 0 sets the idle level of the serial clock: 0 means idle high, 1 means idle low. `cfg_mode` bit 1 picks the sampling edge: 0 samples on odd edges and changes data on even edges, 1 samples on even edges and changes data on odd edges. Edges are numbered from 1 at the start of the frame.
- R3: `cfg_len7`=1 gives a 7-bit frame of 14 clock edges, and `rx_data[7]` reads 0. `cfg_len7`=0 gives an 8-bit frame of 16 edges.
- R4: `cfg_lsb_first`=0 sends and receives the most significant bit first. `cfg_lsb_first`=1 sends and receives the least significant bit first.
- R5: `cfg_dir` selects the data direction. 2'b01 transmits only and never updates the receive register. 2'b10 receives only: `sdo` stays 1 and the written data is ignored, although in master mode a write still starts a frame. Any other value transmits and receives.
- R6: With `cfg_cont`=0, `evt` pulses exactly once per frame, at its last edge, and never in the middle of a frame.
- R7: With `cfg_cont`=1, `evt` pulses when the holding register moves into the shifter. A slave in receive-only mode ignores `cfg_cont` and behaves as in R6.
- R8: A master with a frame already buffered starts it right after the last edge of the current frame. The half period does not change across the boundary. `busy` is high from a write until the last frame ends.
- R9: In slave mode, while `ss_n` is high, serial clock edges are ignored and the frame is held without an event. The frame resumes when `ss_n` returns low.
- R10: If a frame completes while `rx_valid` is set and no read is under way, `ovf` is set and `rx_data` keeps the older frame. `ovf` stays set until a cycle with `ovf_clr` high.
- R11: After reset, `sclk_o` sits at its idle level and `busy`, `rx_valid`, `ovf` and `evt` are low, with `tx_empty` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ck0_en | input | 1 | Operation clock 0 enable |
| ck1_en | input | 1 | Operation clock 1 enable |
| cfg_master | input | 1 | 1 master, 0 slave |
| cfg_ck_sel | input | 1 | Operation clock select |
| cfg_mode | input | 2 | Clock mode code |
| cfg_lsb_first | input | 1 | Bit order |
| cfg_len7 | input | 1 | 7-bit frame select |
| cfg_dir | input | 2 | Data direction |
| cfg_cont | input | 1 | Event on buffer empty |
| cfg_div | input | DIV_W | Half-period reload N |
| tx_wr | input | 1 | Write transmit holding register |
| tx_data | input | DW | Transmit data |
| rx_rd | input | 1 | Read strobe, clears `rx_valid` |
| rx_data | output | DW | Received frame |
| rx_valid | output | 1 | Unread frame present |
| ovf_clr | input | 1 | Clears the overrun flag |
| ovf | output | 1 | Overrun flag |
| busy | output | 1 | Frame running or buffered |
| tx_empty | output | 1 | Holding register free |
| evt | output | 1 | Transfer-end or buffer-empty pulse |
| sclk_o | output | 1 | Master serial clock |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| sclk_i | input | 1 | Slave serial clock |
| ss_n | input | 1 | Slave select, active low |

## Verification
The bench builds the block with its defaults: a 7-bit divider and an 8-bit data width. This means every frame length, the full divider range and both bit orders can be reached. The master frames use a loopback of `sdo` into `sdi`. Divider values of 0 to 3 on both operation-clock enables keep the measured half periods short enough to check all four clock modes. The slave frames run from a bench-driven serial clock with a half period of eight system cycles. That is wide enough for the synchronizers, and it allows a slave-select pause with stray clock edges in the middle of a frame.

// File: rtl/spi_channel.sv
module spi_channel #(
  parameter int DIV_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ck0_en,
  input  logic             ck1_en,
  input  logic             cfg_master,
  input  logic             cfg_ck_sel,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_lsb_first,
  input  logic             cfg_len7,
  input  logic [1:0]       cfg_dir,
  input  logic             cfg_cont,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_data,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  input  logic             ovf_clr,
  output logic             ovf,
  output logic             busy,
  output logic             tx_empty,
  output logic             evt,
  output logic             sclk_o,
  output logic             sdo,
  input  logic             sdi,
  input  logic             sclk_i,
  input  logic             ss_n
);
  localparam int CW = $clog2(2*DW+1);
  localparam int IW = $clog2(DW);

  logic             active, txfull, sclk_q;
  logic [DW-1:0]    txbuf, txsh, rsh, rsh_n;
  logic [CW-1:0]    ecnt, enx, nedge;
  logic [IW-1:0]    oidx, sidx, lenm1, opos, spos;
  logic [DIV_W-1:0] dcnt;
  logic [2:0]       sck_m;
  logic [1:0]       ss_m, sdi_m;

  wire idle_lvl = ~cfg_mode[0];
  wire phase    = cfg_mode[1];
  wire do_tx    = cfg_dir != 2'b10;
  wire do_rx    = cfg_dir != 2'b01;
  wire slv_rx   = !cfg_master && cfg_dir == 2'b10;
  wire cont_eff = cfg_cont && !slv_rx;
  wire opclk    = cfg_ck_sel ? ck1_en : ck0_en;
  wire ss_act   = !ss_m[1];
  wire rx_bit   = cfg_master ? sdi : sdi_m[1];

  assign lenm1 = cfg_len7 ? IW'(DW-2) : IW'(DW-1);
  assign nedge = cfg_len7 ? CW'(2*DW-2) : CW'(2*DW);
  assign opos  = cfg_lsb_first ? oidx : lenm1 - oidx;
  assign spos  = cfg_lsb_first ? sidx : lenm1 - sidx;
  assign enx   = ecnt + CW'(1);

  wire tick = active && (cfg_master ? (opclk && dcnt == '0)
                                    : (ss_act && (sck_m[2] ^ sck_m[1])));
  wire smp  = tick && (enx[0] ^ phase);
  wire chg  = tick && !(enx[0] ^ phase) && !(phase && enx == CW'(1));
  wire last = tick && enx == nedge;
  wire load = (!active || last) && (txfull || slv_rx);
  wire load_buf = load && txfull;

  always_comb begin
    rsh_n = rsh;
    if (smp) rsh_n[spos] = rx_bit;
  end

  assign busy     = active || txfull;
  assign tx_empty = !txfull;
  assign sclk_o   = (cfg_master && active) ? sclk_q : idle_lvl;
  assign sdo      = do_tx ? txsh[opos] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= '0;
      ss_m  <= 2'b11;
      sdi_m <= '0;
    end else begin
      sck_m <= {sck_m[1:0], sclk_i};
      ss_m  <= {ss_m[0], ss_n};
      sdi_m <= {sdi_m[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      txfull <= 1'b0;
      txbuf  <= '0;
      txsh   <= '0;
      rsh    <= '0;
      ecnt   <= '0;
      oidx   <= '0;
      sidx   <= '0;
      dcnt   <= '0;
      sclk_q <= 1'b1;
    end else begin
      txfull <= (txfull && !load_buf) || (tx_wr && !txfull);
      if (tx_wr && !txfull) txbuf <= tx_data;
      if (load) begin
        active <= 1'b1;
        txsh   <= txbuf;
        rsh    <= '0;
        ecnt   <= '0;
        oidx   <= '0;
        sidx   <= '0;
        dcnt   <= cfg_div;
        sclk_q <= idle_lvl;
      end else if (last) begin
        active <= 1'b0;
        sclk_q <= idle_lvl;
      end else if (tick) begin
        ecnt   <= enx;
        sclk_q <= ~sclk_q;
        rsh    <= rsh_n;
        dcnt   <= cfg_div;
        if (chg) oidx <= oidx + IW'(1);
        if (smp) sidx <= sidx + IW'(1);
      end else if (active && cfg_master && opclk) begin
        dcnt <= dcnt - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
      ovf      <= 1'b0;
      evt      <= 1'b0;
    end else begin
      evt <= cont_eff ? load_buf : last;
      if (last && do_rx && rx_valid && !rx_rd) begin
        ovf <= 1'b1;
      end else begin
        if (ovf_clr) ovf <= 1'b0;
        if (last && do_rx) begin
          rx_data  <= rsh_n;
          rx_valid <= 1'b1;
        end else if (rx_rd) begin
          rx_valid <= 1'b0;
        end
      end
    end
  end

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !ovf_clr |=> ovf);
  a_r10_rx_keep: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_rd |=> $stable(rx_data));
  a_r9_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master && !ss_act && active |=> $stable(ecnt));
  a_r1_clock_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $past(cfg_master) && $stable(cfg_mode) && !$stable(sclk_o) |-> $past(active));
  a_r3_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    active && $stable(cfg_len7) |-> ecnt < nedge);
  a_r8_busy_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && tx_empty |=> busy);
endmodule

// File: tb/sim_spi_channel.sv
module sim_spi_channel;
  localparam int TCLK = 10;
  localparam int SHP  = 8;

  logic clk = 0, rst_n = 0, ck1 = 0;
  logic cfg_master = 1, cfg_ck_sel = 0, cfg_lsb = 0, cfg_len7 = 0, cfg_cont = 0;
  logic [1:0] cfg_mode = 0, cfg_dir = 2'b11;
  logic [6:0] cfg_div = 0;
  logic tx_wr = 0, rx_rd = 0, ovf_clr = 0, sclk_i = 1, ss_n = 1, sdi_drv = 0, lb = 1;
  logic [7:0] tx_data = 0;
  wire [7:0] rx_data;
  wire rx_valid, ovf, busy, tx_empty, evt, sclk_o, sdo;
  wire sdi = cfg_master ? (lb ? sdo : sdi_drv) : sdi_drv;

  int checks = 0, fails = 0, cyc = 0;
  int ecount, lastt, hpmin, hpmax, evt_cnt;
  logic [63:0] cap, scap;
  logic pv = 1, m_phase = 0, sdo_low = 0;

  always #(TCLK/2) clk = ~clk;
  always @(negedge clk) ck1 <= ~ck1;

  spi_channel u0 (.clk(clk), .rst_n(rst_n), .ck0_en(1'b1), .ck1_en(ck1),
    .cfg_master(cfg_master), .cfg_ck_sel(cfg_ck_sel), .cfg_mode(cfg_mode),
    .cfg_lsb_first(cfg_lsb), .cfg_len7(cfg_len7), .cfg_dir(cfg_dir),
    .cfg_cont(cfg_cont), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data),
    .rx_rd(rx_rd), .rx_data(rx_data), .rx_valid(rx_valid), .ovf_clr(ovf_clr),
    .ovf(ovf), .busy(busy), .tx_empty(tx_empty), .evt(evt), .sclk_o(sclk_o),
    .sdo(sdo), .sdi(sdi), .sclk_i(sclk_i), .ss_n(ss_n));

  always @(negedge clk) begin
    cyc++;
    if (sclk_o !== pv) begin
      ecount++;
      if ((ecount % 2 == 1) ^ m_phase) cap = {cap[62:0], sdo};
      if (ecount > 1) begin
        if (cyc - lastt < hpmin) hpmin = cyc - lastt;
        if (cyc - lastt > hpmax) hpmax = cyc - lastt;
      end
      lastt = cyc;
    end
    if (busy && cfg_master && sdo == 1'b0) sdo_low = 1;
    if (evt) evt_cnt++;
    pv = sclk_o;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] seq(input logic [7:0] d, input bit lsb, input int len);
    logic [7:0] r = 0;
    for (int i = 0; i < len; i++) r = {r[6:0], lsb ? d[i] : d[len-1-i]};
    return r;
  endfunction

  task automatic clr_mon();
    @(negedge clk);
    ecount = 0; cap = 0; hpmin = 1 << 20; hpmax = 0; evt_cnt = 0; sdo_low = 0;
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_rd();
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
  endtask

  task automatic set_cfg(input bit mst, input logic [1:0] mode, input bit lsb, input bit l7,
                         input logic [1:0] dir, input bit cont, input logic [6:0] div, input bit cks);
    @(negedge clk);
    cfg_master = mst; cfg_mode = mode; cfg_lsb = lsb; cfg_len7 = l7; cfg_dir = dir;
    cfg_cont = cont; cfg_div = div; cfg_ck_sel = cks; m_phase = mode[1];
    sclk_i = ~mode[0];
    repeat (4) @(negedge clk);
    clr_mon();
  endtask

  task automatic t_reset();
    chk(sclk_o == 1 && !busy && !rx_valid && !ovf && !evt && tx_empty, "R11 reset state",
        {sclk_o, busy, rx_valid, ovf, evt, tx_empty}, 6'b100001);
  endtask

  // rxm: 0 no rx check, 1 expect rx data, 2 expect no rx update
  task automatic t_master(input logic [1:0] mode, input bit lsb, input bit l7, input logic [1:0] dir,
                          input logic [6:0] div, input bit cks, input logic [7:0] d,
                          input logic [7:0] exp_rx, input int rxm, input bit rd);
    int len = l7 ? 7 : 8;
    set_cfg(1, mode, lsb, l7, dir, 0, div, cks);
    write(d);
    repeat (4) @(negedge clk);
    chk(evt_cnt == 0 && busy, "R6 no event mid-frame", evt_cnt, 0);
    wait_idle();
    chk(ecount == 2*len, "R3 edge count", ecount, 2*len);
    chk(hpmin == hpmax && hpmax == (div+1)*(cks ? 2 : 1), "R1 half period", hpmax, (div+1)*(cks ? 2 : 1));
    chk(sclk_o == ~mode[0], "R2 idle level", sclk_o, ~mode[0]);
    chk(evt_cnt == 1, "R6 one event per frame", evt_cnt, 1);
    if (dir != 2'b10)
      chk(cap[7:0] == seq(d, lsb, len), "R4 R2 bit stream", cap[7:0], seq(d, lsb, len));
    else
      chk(!sdo_low, "R5 sdo held high in receive-only", sdo_low, 0);
    if (rxm == 1) chk(rx_valid && rx_data == exp_rx, "R5 R3 received data", rx_data, exp_rx);
    if (rxm == 2) chk(!rx_valid, "R5 transmit-only leaves receive register", rx_valid, 0);
    if (rd) pulse_rd();
  endtask

  task automatic t_overrun();
    t_master(2'b00, 0, 0, 2'b11, 1, 0, 8'h11, 8'h11, 1, 0);
    t_master(2'b00, 0, 0, 2'b11, 1, 0, 8'h22, 8'h11, 0, 0);
    chk(ovf == 1, "R10 overrun set", ovf, 1);
    chk(rx_data == 8'h11, "R10 first frame kept", rx_data, 8'h11);
    repeat (5) @(negedge clk);
    chk(ovf == 1, "R10 overrun sticky", ovf, 1);
    @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
    @(negedge clk);
    chk(ovf == 0, "R10 overrun cleared", ovf, 0);
    pulse_rd();
  endtask

  task automatic t_cont();
    set_cfg(1, 2'b00, 0, 0, 2'b01, 1, 1, 0);
    write(8'hC3);
    repeat (2) @(negedge clk);
    chk(evt_cnt == 1 && busy, "R7 event on buffer empty", evt_cnt, 1);
    chk(tx_empty, "R7 buffer free", tx_empty, 1);
    write(8'h5E);
    wait_idle();
    chk(evt_cnt == 2, "R7 two buffer-empty events", evt_cnt, 2);
    chk(ecount == 32, "R8 edges of two frames", ecount, 32);
    chk(hpmin == 2 && hpmax == 2, "R8 no gap between frames", hpmax, 2);
    chk(cap[15:0] == 16'hC35E, "R8 back-to-back stream", cap[15:0], 16'hC35E);
  endtask

  task automatic t_slave(input logic [1:0] mode, input bit lsb, input logic [1:0] dir, input bit cont,
                         input logic [7:0] txd, input logic [7:0] w, input bit pause);
    logic [7:0] b;
    int oi = 0;
    set_cfg(0, mode, lsb, 0, dir, cont, 0, 0);
    for (int i = 0; i < 8; i++) b[i] = lsb ? w[i] : w[7-i];
    scap = 0;
    if (dir != 2'b10) write(txd);
    repeat (SHP) @(negedge clk);
    ss_n = 0;
    if (!mode[1]) sdi_drv = b[0];
    repeat (SHP) @(negedge clk);
    for (int k = 1; k <= 16; k++) begin
      if ((k % 2 == 1) ^ mode[1]) scap = {scap[62:0], sdo};
      else if (mode[1] && k == 1) sdi_drv = b[0];
      else if (oi < 7) begin oi++; sdi_drv = b[oi]; end
      sclk_i = ~sclk_i;
      repeat (SHP) @(negedge clk);
      if (k == 8) chk(evt_cnt == 0, "R6 R7 no slave event mid-frame", evt_cnt, 0);
      if (pause && k == 7) begin
        ss_n = 1;
        repeat (SHP) @(negedge clk);
        sclk_i = ~sclk_i; repeat (SHP) @(negedge clk);
        sclk_i = ~sclk_i; repeat (SHP) @(negedge clk);
        chk(busy && evt_cnt == 0, "R9 paused frame holds without event", evt_cnt, 0);
        ss_n = 0;
        repeat (SHP) @(negedge clk);
      end
    end
    repeat (SHP) @(negedge clk);
    ss_n = 1;
    chk(evt_cnt == 1, "R6 R9 slave event at frame end", evt_cnt, 1);
    chk(rx_valid && rx_data == w, "R9 R4 slave received", rx_data, w);
    if (dir != 2'b10) chk(scap[7:0] == seq(txd, lsb, 8), "R2 R9 slave sent", scap[7:0], seq(txd, lsb, 8));
    pulse_rd();
  endtask

  initial begin
    #(TCLK * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_master(2'b00, 0, 0, 2'b11, 3, 0, 8'hA5, 8'hA5, 1, 1);
    t_master(2'b01, 1, 0, 2'b11, 0, 1, 8'h3C, 8'h3C, 1, 1);
    t_master(2'b10, 0, 1, 2'b11, 2, 0, 8'hD3, 8'h53, 1, 1);
    t_master(2'b11, 1, 1, 2'b00, 1, 1, 8'h2E, 8'h2E, 1, 1);
    t_master(2'b00, 1, 0, 2'b01, 0, 0, 8'h96, 8'h00, 2, 0);
    lb = 0; sdi_drv = 1;
    t_master(2'b01, 0, 0, 2'b10, 1, 0, 8'h00, 8'hFF, 1, 1);
    lb = 1;
    t_overrun();
    t_cont();
    t_slave(2'b00, 0, 2'b11, 0, 8'h96, 8'h4B, 1);
    t_slave(2'b10, 1, 2'b11, 0, 8'h81, 8'h7E, 0);
    t_slave(2'b01, 0, 2'b10, 1, 8'h00, 8'hB4, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule